// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating Controller

This block sits between a set of clock dividers and the output pins of a clock generator. It passes each divided clock through an output gate. It closes or opens groups of those gates in response to three active-low control inputs: a processor-clock halt, a bus-clock halt and a power-down request. Every divided clock arrives as a level that is registered in the fast base-clock domain. The gates change state only while their own clock is low, so an output is either silent or carries whole pulses.

The halt inputs are synchronous to the free-running bus clock. They are sampled on its rising edges, so start and stop latency counts in those edges. The processor halt silences the processor and 66 MHz groups and leaves the rest running. The bus halt silences the gated bus outputs and spares the free-running bus output. Power-down is asynchronous and passes through a two-flop synchronizer. It silences every group, including the reference and auxiliary outputs, and only then drops the oscillator and VCO enables.

On release from power-down, the enables come back and a counter of reference-clock rising edges (default sized for about 3 ms) must expire before any gate reopens. Reset places the block in the powered-down state.

Top module: `clkstop_pm`

## Requirements
- R1: While reset is asserted, every clock output, `osc_en` and `vco_en` are low.
- R2: With `cpu_halt_n` low and power up, all `cpu_ck_o` and `m66_ck_o` bits stay low. `pci_ck_o`, `pcif_ck_o` and `aux_ck_o` keep toggling.
- R3: With `pci_halt_n` low and power up, all `pci_ck_o` bits stay low while `pcif_ck_o` keeps toggling.
- R4: With `pwr_dn_n` low (after entry), every clock output and both `osc_en`/`vco_en` are low, whatever the halt inputs are. The enables never drop while any output is still high.
- R5: A halt input is sampled on each rising edge of `pcif_ck_i`. The affected gates close (stop) or open (restart) at the next low phase of their clock. No earlier change is visible.
- R6: After `pwr_dn_n` falls, the block stops requesting clocks at the second `pcif_ck_i` rising edge after synchronization. It turns the enables off once all gates are closed.
- R7: After `pwr_dn_n` rises, `osc_en`/`vco_en` return at once. All outputs stay low until `WAKE_REFS` rising edges of `aux_ck_i[REF_IDX]` have been counted.
- R8: Every output high phase is a complete high phase of its input clock: an output rises only with its input and, once high, stays high as long as its input does.
- R9: If `pwr_dn_n` falls again during the wake-up wait, the block returns directly to the powered-down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock in which all divided clocks are registered |
| rst_n | input | 1 | Active-low reset, enters power-down state |
| cpu_halt_n | input | 1 | Active-low processor/66 MHz group halt, synchronous to the free bus clock |
| pci_halt_n | input | 1 | Active-low gated bus group halt, synchronous to the free bus clock |
| pwr_dn_n | input | 1 | Active-low asynchronous power-down request |
| cpu_ck_i | input | N_CPU | Divided processor clocks |
| m66_ck_i | input | N_66 | Divided 66 MHz clocks |
| pci_ck_i | input | N_PCI | Divided gated bus clocks |
| pcif_ck_i | input | 1 | Divided free-running bus clock, also the latency reference |
| aux_ck_i | input | N_AUX | Halt-exempt clocks (half-rate, interrupt, reference, USB); bit REF_IDX is the reference |
| cpu_ck_o | output | N_CPU | Gated processor clocks |
| m66_ck_o | output | N_66 | Gated 66 MHz clocks |
| pci_ck_o | output | N_PCI | Gated bus clocks |
| pcif_ck_o | output | 1 | Free-running bus clock, gated by power-down only |
| aux_ck_o | output | N_AUX | Halt-exempt clocks, gated by power-down only |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | PLL VCO enable |

## Verification
The assertions check the following on every cycle:
- each gated output rises only with its input and never ends a high phase early;
- all outputs are dark whenever the enables are off and throughout the wake-up wait;
- the wake counter stays in range;
- a power-down during wake-up aborts it.

The bench's scenarios cover what a per-cycle property cannot show: the group-by-group effect of all eight halt and power-down combinations, and the one-edge latency bound from both sides. They also cover the power-down entry and exit timing, measured against the bus clock and the reference-edge count.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    PM_OFF   = 2'd0,
    PM_WAKE  = 2'd1,
    PM_RUN   = 2'd2,
    PM_DRAIN = 2'd3
  } pm_state_e;

  // true when the wake counter sits on its final reference edge
  function automatic logic wake_last(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pm_gate.sv
module pm_gate #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ck_i,
  input  logic         req,
  output logic [W-1:0] ck_o,
  output logic         any_open
);
  logic [W-1:0] en_vec;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic en_q;
      // enable may only move while this clock is low
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (!ck_i[i]) en_q <= req;
      end
      assign en_vec[i] = en_q;
      assign ck_o[i]   = ck_i[i] & en_q;

      // R8
      no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ck_o[i]) && ck_i[i]) |-> ck_o[i]);
      // R8
      no_midrise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ck_o[i]) |-> $rose(ck_i[i]));
    end
  endgenerate

  assign any_open = |en_vec;
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_pkg::*;
#(
  parameter int unsigned WAKE_REFS = 42955
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_ok,
  input  logic pci_edge,
  input  logic ref_edge,
  input  logic all_shut,
  output logic live,
  output logic osc_on,
  output logic waking
);
  localparam int CW = $clog2(WAKE_REFS + 1);

  pm_state_e     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PM_OFF;
      cnt   <= '0;
    end else begin
      unique case (state)
        PM_OFF: if (pd_ok) begin
          state <= PM_WAKE;
          cnt   <= '0;
        end
        PM_WAKE: begin
          if (!pd_ok) state <= PM_OFF;
          else if (ref_edge) begin
            if (wake_last(32'(cnt), WAKE_REFS)) state <= PM_RUN;
            else cnt <= cnt + 1'b1;
          end
        end
        PM_RUN:   if (!pd_ok && pci_edge) state <= PM_DRAIN;
        PM_DRAIN: if (all_shut) state <= PM_OFF;
        default:  state <= PM_OFF;
      endcase
    end
  end

  assign live   = (state == PM_RUN);
  assign osc_on = (state != PM_OFF);
  assign waking = (state == PM_WAKE);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_WAKE) |-> (32'(cnt) < WAKE_REFS));
  // R9
  wake_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_WAKE && !pd_ok) |=> (state == PM_OFF));
endmodule

// File: rtl/clkstop_pm.sv
module clkstop_pm #(
  parameter int          N_CPU     = 4,
  parameter int          N_66      = 4,
  parameter int          N_PCI     = 7,
  parameter int          N_AUX     = 4,
  parameter int          REF_IDX   = 0,
  parameter int unsigned WAKE_REFS = 42955
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_halt_n,
  input  logic             pci_halt_n,
  input  logic             pwr_dn_n,
  input  logic [N_CPU-1:0] cpu_ck_i,
  input  logic [N_66-1:0]  m66_ck_i,
  input  logic [N_PCI-1:0] pci_ck_i,
  input  logic             pcif_ck_i,
  input  logic [N_AUX-1:0] aux_ck_i,
  output logic [N_CPU-1:0] cpu_ck_o,
  output logic [N_66-1:0]  m66_ck_o,
  output logic [N_PCI-1:0] pci_ck_o,
  output logic             pcif_ck_o,
  output logic [N_AUX-1:0] aux_ck_o,
  output logic             osc_en,
  output logic             vco_en
);
  logic pd_ok, live, osc_on, waking, all_shut;
  logic pcif_q, ref_q, pci_edge, ref_edge;
  logic cpu_req, pci_req, free_req;
  logic open_cpu, open_66, open_pci, open_f, open_aux;

  pm_sync #(.STAGES(2)) u_pd_sync (
    .clk(clk), .rst_n(rst_n), .d(pwr_dn_n), .q(pd_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcif_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      pcif_q <= pcif_ck_i;
      ref_q  <= aux_ck_i[REF_IDX];
    end
  end

  assign pci_edge = pcif_ck_i & ~pcif_q;
  assign ref_edge = aux_ck_i[REF_IDX] & ~ref_q;

  // group requests move only on free bus clock rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_req  <= 1'b0;
      pci_req  <= 1'b0;
      free_req <= 1'b0;
    end else if (pci_edge) begin
      cpu_req  <= live & cpu_halt_n;
      pci_req  <= live & pci_halt_n;
      free_req <= live;
    end
  end

  pm_gate #(.W(N_CPU)) u_g_cpu (.clk(clk), .rst_n(rst_n), .ck_i(cpu_ck_i),
    .req(cpu_req), .ck_o(cpu_ck_o), .any_open(open_cpu));
  pm_gate #(.W(N_66)) u_g_66 (.clk(clk), .rst_n(rst_n), .ck_i(m66_ck_i),
    .req(cpu_req), .ck_o(m66_ck_o), .any_open(open_66));
  pm_gate #(.W(N_PCI)) u_g_pci (.clk(clk), .rst_n(rst_n), .ck_i(pci_ck_i),
    .req(pci_req), .ck_o(pci_ck_o), .any_open(open_pci));
  pm_gate #(.W(1)) u_g_pcif (.clk(clk), .rst_n(rst_n), .ck_i(pcif_ck_i),
    .req(free_req), .ck_o(pcif_ck_o), .any_open(open_f));
  pm_gate #(.W(N_AUX)) u_g_aux (.clk(clk), .rst_n(rst_n), .ck_i(aux_ck_i),
    .req(free_req), .ck_o(aux_ck_o), .any_open(open_aux));

  assign all_shut = ~(open_cpu | open_66 | open_pci | open_f | open_aux |
                      cpu_req | pci_req | free_req);

  pm_seq #(.WAKE_REFS(WAKE_REFS)) u_seq (
    .clk(clk), .rst_n(rst_n), .pd_ok(pd_ok), .pci_edge(pci_edge),
    .ref_edge(ref_edge), .all_shut(all_shut), .live(live),
    .osc_on(osc_on), .waking(waking)
  );

  assign osc_en = osc_on;
  assign vco_en = osc_on;

  logic any_out;
  assign any_out = |{cpu_ck_o, m66_ck_o, pci_ck_o, pcif_ck_o, aux_ck_o};

  // R4
  dark_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !any_out);
  // R7
  dark_in_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> !any_out);
endmodule

// File: tb/clkstop_pm_bench.sv
module clkstop_pm_bench;
  localparam int NC = 4, N6 = 4, NP = 7, NA = 2, WR = 16;
  localparam int NT = NC + N6 + NP + 1 + NA;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cpu_halt_n = 1'b1, pci_halt_n = 1'b1, pwr_dn_n = 1'b1;
  int unsigned cnt = 0;
  always @(posedge clk) cnt <= cnt + 1;

  logic [NC-1:0] cpu_i, cpu_o;
  logic [N6-1:0] m66_i, m66_o;
  logic [NP-1:0] pci_i, pci_o;
  logic pcif_i, pcif_o, osc_en, vco_en;
  logic [NA-1:0] aux_i, aux_o;

  assign cpu_i  = {NC{cnt[0]}};
  assign m66_i  = {N6{cnt[1]}};
  assign pci_i  = {NP{cnt[2]}};
  assign pcif_i = cnt[2];
  assign aux_i  = {((cnt % 10) < 5), ((cnt % 6) < 3)};

  clkstop_pm #(.N_CPU(NC), .N_66(N6), .N_PCI(NP), .N_AUX(NA),
               .REF_IDX(0), .WAKE_REFS(WR)) u_clkstop_pm (
    .clk(clk), .rst_n(rst_n), .cpu_halt_n(cpu_halt_n), .pci_halt_n(pci_halt_n),
    .pwr_dn_n(pwr_dn_n), .cpu_ck_i(cpu_i), .m66_ck_i(m66_i), .pci_ck_i(pci_i),
    .pcif_ck_i(pcif_i), .aux_ck_i(aux_i), .cpu_ck_o(cpu_o), .m66_ck_o(m66_o),
    .pci_ck_o(pci_o), .pcif_ck_o(pcif_o), .aux_ck_o(aux_o),
    .osc_en(osc_en), .vco_en(vco_en)
  );

  int total = 0, bad = 0, runts = 0;
  bit done = 0;
  logic [NT-1:0] all_o;
  assign all_o = {aux_o, pcif_o, pci_o, m66_o, cpu_o};

  // input half periods in base-clock cycles, from the divider model above
  function automatic int half_of(input int idx);
    if (idx < NC) return 1;
    if (idx < NC + N6) return 2;
    if (idx < NC + N6 + NP + 1) return 4;
    if (idx == NC + N6 + NP + 1) return 3;
    return 5;
  endfunction

  int run [NT];
  initial for (int i = 0; i < NT; i++) run[i] = 0;
  // R8 pulse-width monitor
  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < NT; i++) begin
      if (all_o[i]) run[i]++;
      else begin
        if (run[i] != 0 && run[i] != half_of(i)) runts++;
        run[i] = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int hc, h6, hp, hf, ha, ho;
  task automatic observe(input int n);
    hc = 0; h6 = 0; hp = 0; hf = 0; ha = 0; ho = 0;
    repeat (n) begin
      @(negedge clk);
      if (|cpu_o) hc++;
      if (|m66_o) h6++;
      if (|pci_o) hp++;
      if (pcif_o) hf++;
      if (|aux_o) ha++;
      if (osc_en && vco_en) ho++;
    end
  endtask

  function automatic int dark();
    return hc + h6 + hp + hf + ha;
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    observe(5);
    chk(dark() == 0, "R1 outputs in reset", dark(), 0);
    chk(ho == 0 && !osc_en && !vco_en, "R1 enables in reset", ho, 0);
    @(negedge clk) rst_n = 1'b1;

    // R7 wake wait after reset
    observe(80);
    chk(dark() == 0, "R7 dark during wake", dark(), 0);
    chk(ho >= 76, "R7 enables back", ho, 76);
    repeat (70) @(negedge clk);
    observe(40);
    chk(hc > 0 && ha > 0, "R7 clocks after wake", hc, 1);

    // R2 R3 R4 sweep over all control combinations
    for (int code = 0; code < 8; code++) begin
      bit c, p, d;
      c = code[0]; p = code[1]; d = code[2];
      @(negedge clk);
      cpu_halt_n = c; pci_halt_n = p; pwr_dn_n = d;
      repeat (150) @(negedge clk);
      observe(40);
      chk((hc > 0) == (c && d), "R2 cpu group", hc, int'(c && d));
      chk((h6 > 0) == (c && d), "R2 66 group", h6, int'(c && d));
      chk((hp > 0) == (p && d), "R3 gated pci group", hp, int'(p && d));
      chk((hf > 0) == d, "R3 free pci", hf, int'(d));
      chk((ha > 0) == d, "R4 aux group", ha, int'(d));
      chk(ho == (d ? 40 : 0), "R4 osc/vco enables", ho, d ? 40 : 0);
    end

    // R5 stop latency: one free bus edge
    @(posedge pcif_i);
    repeat (2) @(negedge clk);
    cpu_halt_n = 1'b0;
    observe(5);
    chk(hc > 0, "R5 cpu still running before edge", hc, 1);
    repeat (5) @(negedge clk);
    observe(24);
    chk(hc == 0 && h6 == 0, "R5 cpu stopped after edge", hc + h6, 0);
    chk(hp > 0 && ha > 0, "R5 others unaffected", hp, 1);
    // R5 restart latency
    @(posedge pcif_i);
    repeat (2) @(negedge clk);
    cpu_halt_n = 1'b1;
    observe(5);
    chk(hc == 0, "R5 cpu not early", hc, 0);
    repeat (5) @(negedge clk);
    observe(24);
    chk(hc > 0 && h6 > 0, "R5 cpu restarted", hc, 1);

    // R6 power-down entry
    @(negedge clk) pwr_dn_n = 1'b0;
    observe(2);
    chk(ho == 2, "R6 enables held at entry", ho, 2);
    repeat (30) @(negedge clk);
    observe(20);
    chk(dark() == 0 && ho == 0, "R6 off within bound", dark() + ho, 0);
    @(negedge clk) pwr_dn_n = 1'b1;
    observe(80);
    chk(dark() == 0, "R7 dark after release", dark(), 0);
    repeat (70) @(negedge clk);
    observe(40);
    chk(hc > 0 && hf > 0, "R7 running after release", hc, 1);

    // R9 abort during wake
    @(negedge clk) pwr_dn_n = 1'b0;
    repeat (40) @(negedge clk);
    pwr_dn_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(osc_en == 1'b1, "R9 waking", int'(osc_en), 1);
    pwr_dn_n = 1'b0;
    repeat (6) @(negedge clk);
    observe(10);
    chk(ho == 0 && dark() == 0, "R9 abort to off", ho + dark(), 0);
    pwr_dn_n = 1'b1;
    repeat (150) @(negedge clk);
    observe(40);
    chk(hc > 0 && ha > 0, "R9 recovers", hc, 1);

    // R8 no shortened pulses seen anywhere
    chk(runts == 0, "R8 runt pulses", runts, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule